// File: doc/BRIEF.md
# Multi-Phase Quad SPI Write Serializer

This block sends one serial write frame built from up to three phases, always in the order command, address, data. Each phase is a list of 32-bit words fetched from the host one at a time and has its own lane width, either one data line or four. A phase with no words is skipped. Words go out most significant bit first. The final word of a phase and the word before it can each be shortened to a configured number of shift clocks. The host left-aligns the bits that are to be sent.

The host sets the configuration ports and pulses `start_i`. The block captures the whole configuration on that pulse and raises busy. It then asserts chip-enable at the selected polarity and fetches the first word over a same-cycle fetch port. After that it runs the serial clock from a reload counter. The next word is held in a spare register and moves in at the word boundary, so the clock has no gaps between words or between phases.

After the last word, the data lines drop to zero. By default one surplus clock pulse follows, sent with zero data. An option removes this pulse. When the frame ends, chip-enable is released unless the hold option was captured, and `done_o` pulses for one cycle.

Top module: `qtx_serializer`

## Requirements
- R1: Words are fetched and sent in phase order command (phase code 0), address (1), data (2), and by ascending index within a phase. A phase with a word count of zero produces no fetch and no clocks.
- R2: In four-lane mode, each shift clock presents the next four bits of the word, with the most significant of them on `dq_o[3]`. In one-lane mode, the next bit appears on `dq_o[0]` and the other lanes are 0.
- R3: A word takes 32/W shift clocks, where W is the lane width. The last word of a phase takes last_m1+1 clocks and the second-to-last takes pen_m1+1. Both counts are encoded as clocks minus one and are limited to 32/W. With one word, only the last-word count applies.
- R4: `sclk_o` idles low and toggles every clk_div+1 cycles while running, so each high level lasts clk_div+1 cycles. `dq_o` changes only while `sclk_o` is low.
- R5: There are no idle clocks between words or between phases. For B transmitted shifts with no trailing pulse, busy lasts exactly 2 + B·2·(clk_div+1) cycles.
- R6: Chip-enable equals `ce_active_high_i` as captured at start on every rising edge of `sclk_o`. At reset, `ce_o` is 1.
- R7: When the frame ends, chip-enable stays asserted if the hold option was captured. Otherwise it returns to the inactive level in the cycle where `done_o` is high.
- R8: With `trim_tail_i` = 0, one extra clock pulse follows the last word with all lanes at 0, which adds 2·(clk_div+1) busy cycles. With `trim_tail_i` = 1, no extra pulse is sent.
- R9: Whenever busy is low, `sclk_o` and `dq_o` are 0.
- R10: `done_o` is a one-cycle pulse at the end of each frame, and busy is low in that cycle. A start pulse or configuration change while busy has no effect on the frame in progress.
- R11: A frame in which all three word counts are zero is busy for one cycle, sends no clocks and fetches nothing. It still applies the end-of-frame chip-enable rule of R7.
- R12: After reset, `sclk_o`=0, `dq_o`=0, `ce_o`=1, `busy_o`=0, `done_o`=0 and `word_req_o`=0.
- R13: `word_req_o` is high for exactly one cycle per word, with `word_phase_o` and `word_index_o` naming that word. `word_i` is taken in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a frame (ignored while busy) |
| clk_div_i | input | DIV_W | Half-period of the serial clock, minus one, in clk cycles |
| ce_active_high_i | input | 1 | 1: chip-enable is asserted high; 0: asserted low |
| ce_hold_i | input | 1 | Keep chip-enable asserted after the frame |
| trim_tail_i | input | 1 | Omit the trailing surplus clock pulse |
| phase_words_i | input | 3*CNT_W | Word count per phase, with phase p at bits p*CNT_W |
| phase_quad_i | input | 3 | Per phase: 1 = four lanes, 0 = one lane |
| phase_last_m1_i | input | 3*SHW | Per phase: clocks for the last word, minus one |
| phase_pen_m1_i | input | 3*SHW | Per phase: clocks for the second-to-last word, minus one |
| word_i | input | WORD_W | Word returned for the current fetch |
| sclk_o | output | 1 | Serial clock |
| dq_o | output | LANES | Data lanes |
| ce_o | output | 1 | Chip-enable |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| word_req_o | output | 1 | Word fetch strobe |
| word_phase_o | output | 2 | Phase of the fetched word |
| word_index_o | output | CNT_W | Index of the fetched word within its phase |

## Verification
The frames applied cover several phase layouts:
- all three phases present with mixed lane widths;
- data-only frames;
- a command and address frame with no data;
- a frame of single-bit words;
- a frame with no words at all.

Together they separate skipping empty phases from mis-ordering phases, and one-lane bit placement from four-lane nibble placement. Per-phase counts for the last and second-to-last words include a value beyond the full word, a one-clock word and a full-length shortened word. These expose wrong count selection, a missing limit and off-by-one errors in the minus-one encoding. Every frame is checked for the captured bit stream, the fetch order, the exact busy length, high-level widths and the chip-enable level. Across frames, the divider, polarity, hold and trailing-pulse options vary, so each can be told apart from its default.

// File: rtl/qtx_pkg.sv
package qtx_pkg;

    localparam int unsigned QTX_NPH  = 3;
    localparam int unsigned QTX_PH_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_LOAD,
        ST_RUN,
        ST_TAIL
    } qtx_state_e;

endpackage

// File: rtl/qtx_sclk_timer.sv
module qtx_sclk_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] top_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == top_i);
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/qtx_word_planner.sv
module qtx_word_planner
    import qtx_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LANES  = 4,
    parameter int CNT_W  = 8,
    parameter int SHW    = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      init_i,
    input  logic                      advance_i,
    input  logic [QTX_NPH*CNT_W-1:0]  words_i,
    input  logic [QTX_NPH-1:0]        quad_i,
    input  logic [QTX_NPH*SHW-1:0]    last_m1_i,
    input  logic [QTX_NPH*SHW-1:0]    pen_m1_i,
    output logic                      any_o,
    output logic                      valid_o,
    output logic [QTX_PH_W-1:0]       phase_o,
    output logic [CNT_W-1:0]          index_o,
    output logic [SHW-1:0]            shift_m1_o,
    output logic                      quad_o
);

    localparam int unsigned SLOTS = 2 ** QTX_PH_W;
    localparam logic [SHW-1:0] FULL_X1_M1 = SHW'(WORD_W - 1);
    localparam logic [SHW-1:0] FULL_X4_M1 = SHW'(WORD_W / LANES - 1);

    typedef struct packed {
        logic                valid;
        logic [QTX_PH_W-1:0] ph;
        logic [CNT_W-1:0]    idx;
    } cursor_t;

    cursor_t cur_d, cur_q;

    logic [CNT_W-1:0] cnt_a  [SLOTS];
    logic             quad_a [SLOTS];
    logic [SHW-1:0]   last_a [SLOTS];
    logic [SHW-1:0]   pen_a  [SLOTS];

    for (genvar p = 0; p < SLOTS; p++) begin : g_slot
        if (p < QTX_NPH) begin : g_used
            assign cnt_a[p]  = words_i[p*CNT_W +: CNT_W];
            assign quad_a[p] = quad_i[p];
            assign last_a[p] = last_m1_i[p*SHW +: SHW];
            assign pen_a[p]  = pen_m1_i[p*SHW +: SHW];
        end else begin : g_spare
            assign cnt_a[p]  = '0;
            assign quad_a[p] = 1'b0;
            assign last_a[p] = '0;
            assign pen_a[p]  = '0;
        end
    end

    cursor_t          seek_first, seek_after;
    logic [CNT_W:0]   idx_inc;
    logic [CNT_W-1:0] remain;
    logic [SHW-1:0]   full_m1, pick_m1;

    always_comb begin
        seek_first = '0;
        seek_after = '0;
        any_o      = 1'b0;
        for (int p = 0; p < QTX_NPH; p++) begin
            if (cnt_a[p] != '0) begin
                any_o = 1'b1;
                if (!seek_first.valid) begin
                    seek_first = '{valid: 1'b1, ph: QTX_PH_W'(p), idx: '0};
                end
                if (!seek_after.valid && (p > int'(cur_q.ph))) begin
                    seek_after = '{valid: 1'b1, ph: QTX_PH_W'(p), idx: '0};
                end
            end
        end

        idx_inc = {1'b0, cur_q.idx} + 1'b1;
        remain  = cnt_a[cur_q.ph] - cur_q.idx;
        full_m1 = quad_a[cur_q.ph] ? FULL_X4_M1 : FULL_X1_M1;
        if (remain == CNT_W'(1)) begin
            pick_m1 = last_a[cur_q.ph];
        end else if (remain == CNT_W'(2)) begin
            pick_m1 = pen_a[cur_q.ph];
        end else begin
            pick_m1 = full_m1;
        end
        shift_m1_o = (pick_m1 > full_m1) ? full_m1 : pick_m1;

        valid_o = cur_q.valid;
        phase_o = cur_q.ph;
        index_o = cur_q.idx;
        quad_o  = quad_a[cur_q.ph];

        cur_d = cur_q;
        if (init_i) begin
            cur_d = seek_first;
        end else if (advance_i && cur_q.valid) begin
            if (idx_inc < {1'b0, cnt_a[cur_q.ph]}) begin
                cur_d.idx = idx_inc[CNT_W-1:0];
            end else begin
                cur_d = seek_after;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

endmodule

// File: rtl/qtx_shift_lanes.sv
module qtx_shift_lanes #(
    parameter int WORD_W = 32,
    parameter int LANES  = 4,
    parameter int SHW    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prime_i,
    input  logic              fill_i,
    input  logic              bit_end_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [SHW-1:0]    m1_i,
    input  logic              quad_i,
    output logic [LANES-1:0]  dq_o,
    output logic              last_bit_o,
    output logic              spare_full_o
);

    typedef struct packed {
        logic              live;
        logic              quad;
        logic [SHW-1:0]    m1;
        logic [WORD_W-1:0] data;
    } slot_t;

    typedef struct packed {
        slot_t act;
        slot_t spare;
    } lanes_t;

    lanes_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (prime_i) begin
            st_d.act = '{live: 1'b1, quad: quad_i, m1: m1_i, data: word_i};
        end else if (bit_end_i && st_q.act.live) begin
            if (st_q.act.m1 != '0) begin
                st_d.act.m1   = st_q.act.m1 - 1'b1;
                st_d.act.data = st_q.act.quad ? (st_q.act.data << LANES)
                                              : (st_q.act.data << 1);
            end else if (st_q.spare.live) begin
                st_d.act        = st_q.spare;
                st_d.spare.live = 1'b0;
            end else begin
                st_d.act.live = 1'b0;
                st_d.act.data = '0;
            end
        end
        if (fill_i) begin
            st_d.spare = '{live: 1'b1, quad: quad_i, m1: m1_i, data: word_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign last_bit_o   = (st_q.act.m1 == '0);
    assign spare_full_o = st_q.spare.live;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if (l == 0) begin : g_base
            assign dq_o[l] = st_q.act.live &
                (st_q.act.quad ? st_q.act.data[WORD_W-LANES] : st_q.act.data[WORD_W-1]);
        end else begin : g_wide
            assign dq_o[l] = st_q.act.live & st_q.act.quad & st_q.act.data[WORD_W-LANES+l];
        end
    end

endmodule

// File: rtl/qtx_serializer.sv
module qtx_serializer
    import qtx_pkg::*;
#(
    parameter  int WORD_W = 32,
    parameter  int LANES  = 4,
    parameter  int CNT_W  = 8,
    parameter  int DIV_W  = 8,
    localparam int SHW    = $clog2(WORD_W)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [DIV_W-1:0]          clk_div_i,
    input  logic                      ce_active_high_i,
    input  logic                      ce_hold_i,
    input  logic                      trim_tail_i,
    input  logic [QTX_NPH*CNT_W-1:0]  phase_words_i,
    input  logic [QTX_NPH-1:0]        phase_quad_i,
    input  logic [QTX_NPH*SHW-1:0]    phase_last_m1_i,
    input  logic [QTX_NPH*SHW-1:0]    phase_pen_m1_i,
    input  logic [WORD_W-1:0]         word_i,
    output logic                      sclk_o,
    output logic [LANES-1:0]          dq_o,
    output logic                      ce_o,
    output logic                      busy_o,
    output logic                      done_o,
    output logic                      word_req_o,
    output logic [QTX_PH_W-1:0]       word_phase_o,
    output logic [CNT_W-1:0]          word_index_o
);

    typedef struct packed {
        logic [QTX_NPH*CNT_W-1:0] words;
        logic [QTX_NPH-1:0]       quad;
        logic [QTX_NPH*SHW-1:0]   last_m1;
        logic [QTX_NPH*SHW-1:0]   pen_m1;
        logic [DIV_W-1:0]         top;
        logic                     pol;
        logic                     hold;
        logic                     trim;
    } cfg_t;

    typedef struct packed {
        qtx_state_e state;
        logic       sclk;
        logic       ce_on;
        logic       done;
        cfg_t       cfg;
    } regs_t;

    regs_t r_d, r_q;

    logic             tick, rise_unused, fall;
    logic             plan_any, plan_valid, plan_quad;
    logic [SHW-1:0]   plan_m1;
    logic             fetch, prime, fill, init, bit_end;
    logic             last_bit, spare_full;
    logic             ce_pol_q, ce_hold_q;

    qtx_sclk_timer #(
        .DIV_W (DIV_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  ((r_q.state == ST_RUN) || (r_q.state == ST_TAIL)),
        .top_i  (r_q.cfg.top),
        .tick_o (tick)
    );

    qtx_word_planner #(
        .WORD_W (WORD_W),
        .LANES  (LANES),
        .CNT_W  (CNT_W),
        .SHW    (SHW)
    ) u_planner (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (init),
        .advance_i  (fetch),
        .words_i    (r_q.cfg.words),
        .quad_i     (r_q.cfg.quad),
        .last_m1_i  (r_q.cfg.last_m1),
        .pen_m1_i   (r_q.cfg.pen_m1),
        .any_o      (plan_any),
        .valid_o    (plan_valid),
        .phase_o    (word_phase_o),
        .index_o    (word_index_o),
        .shift_m1_o (plan_m1),
        .quad_o     (plan_quad)
    );

    qtx_shift_lanes #(
        .WORD_W (WORD_W),
        .LANES  (LANES),
        .SHW    (SHW)
    ) u_lanes (
        .clk          (clk),
        .rst_n        (rst_n),
        .prime_i      (prime),
        .fill_i       (fill),
        .bit_end_i    (bit_end),
        .word_i       (word_i),
        .m1_i         (plan_m1),
        .quad_i       (plan_quad),
        .dq_o         (dq_o),
        .last_bit_o   (last_bit),
        .spare_full_o (spare_full)
    );

    always_comb begin
        prime       = (r_q.state == ST_LOAD) && plan_valid;
        fill        = (r_q.state == ST_RUN) && plan_valid && !spare_full;
        fetch       = prime || fill;
        init        = (r_q.state == ST_PREP);
        rise_unused = tick && !r_q.sclk;
        fall        = tick && r_q.sclk;
        bit_end     = fall && (r_q.state == ST_RUN);

        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state       = ST_PREP;
                    r_d.cfg.words   = phase_words_i;
                    r_d.cfg.quad    = phase_quad_i;
                    r_d.cfg.last_m1 = phase_last_m1_i;
                    r_d.cfg.pen_m1  = phase_pen_m1_i;
                    r_d.cfg.top     = clk_div_i;
                    r_d.cfg.pol     = ce_active_high_i;
                    r_d.cfg.hold    = ce_hold_i;
                    r_d.cfg.trim    = trim_tail_i;
                end
            end
            ST_PREP: begin
                if (plan_any) begin
                    r_d.state = ST_LOAD;
                    r_d.ce_on = 1'b1;
                end else begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.ce_on = r_q.ce_on && r_q.cfg.hold;
                end
            end
            ST_LOAD: begin
                r_d.state = ST_RUN;
            end
            ST_RUN: begin
                if (tick) begin
                    r_d.sclk = !r_q.sclk;
                end
                if (fall && last_bit && !spare_full && !plan_valid) begin
                    if (r_q.cfg.trim) begin
                        r_d.state = ST_IDLE;
                        r_d.sclk  = 1'b0;
                        r_d.done  = 1'b1;
                        r_d.ce_on = r_q.cfg.hold;
                    end else begin
                        r_d.state = ST_TAIL;
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    r_d.sclk = !r_q.sclk;
                end
                if (fall) begin
                    r_d.state = ST_IDLE;
                    r_d.sclk  = 1'b0;
                    r_d.done  = 1'b1;
                    r_d.ce_on = r_q.cfg.hold;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ce_pol_q   = r_q.cfg.pol;
    assign ce_hold_q  = r_q.cfg.hold;
    assign sclk_o     = r_q.sclk;
    assign ce_o       = r_q.cfg.pol ? r_q.ce_on : !r_q.ce_on;
    assign busy_o     = (r_q.state != ST_IDLE);
    assign done_o     = r_q.done;
    assign word_req_o = fetch;

endmodule

// File: rtl/qtx_serializer_chk.sv
module qtx_serializer_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sclk_o,
    input logic [LANES-1:0] dq_o,
    input logic             ce_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             word_req_o,
    input logic [1:0]       word_phase_o,
    input logic             pol_i,
    input logic             hold_i
);

    // R9
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sclk_o);

    // R9
    lanes_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (dq_o == '0));

    // R4
    dq_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dq_o) |-> !sclk_o);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R6
    ce_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> (ce_o == pol_i));

    // R7
    ce_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !hold_i) |-> (ce_o != pol_i));

    // R13
    fetch_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_req_o |-> (busy_o && (word_phase_o != 2'd3)));

endmodule

bind qtx_serializer qtx_serializer_chk #(
    .LANES (LANES)
) u_qtx_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk_o       (sclk_o),
    .dq_o         (dq_o),
    .ce_o         (ce_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .word_req_o   (word_req_o),
    .word_phase_o (word_phase_o),
    .pol_i        (ce_pol_q),
    .hold_i       (ce_hold_q)
);

// File: tb/test_qtx_serializer.sv
`timescale 1ns/1ps
module test_qtx_serializer;

    localparam real CLK_HALF = 2.5;

    typedef struct packed {
        logic [7:0] n0, n1, n2;
        logic [2:0] quad;
        logic [4:0] l0, l1, l2;
        logic [4:0] p0, p1, p2;
        logic [7:0] top;
        logic       pol, hold, trim;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{8'd1, 8'd1, 8'd3, 3'b110, 5'd7, 5'd5, 5'd3, 5'd0, 5'd0, 5'd7, 8'd1, 1'b0, 1'b0, 1'b0},
        '{8'd0, 8'd0, 8'd2, 3'b000, 5'd0, 5'd0, 5'd15, 5'd0, 5'd0, 5'd31, 8'd0, 1'b1, 1'b1, 1'b1},
        '{8'd1, 8'd2, 8'd0, 3'b001, 5'd1, 5'd4, 5'd0, 5'd0, 5'd3, 5'd0, 8'd2, 1'b0, 1'b0, 1'b1},
        '{8'd0, 8'd0, 8'd4, 3'b100, 5'd0, 5'd0, 5'd9, 5'd0, 5'd0, 5'd2, 8'd0, 1'b1, 1'b0, 1'b0},
        '{8'd2, 8'd0, 8'd1, 3'b000, 5'd0, 5'd0, 5'd31, 5'd0, 5'd0, 5'd0, 8'd3, 1'b0, 1'b1, 1'b0},
        '{8'd0, 8'd0, 8'd0, 3'b000, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 8'd1, 1'b0, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [7:0]  clk_div;
    logic        pol, hold, trim;
    logic [23:0] words;
    logic [2:0]  quad;
    logic [14:0] last_m1, pen_m1;
    logic [31:0] word_in;
    logic        sclk, ce, busy, done, word_req;
    logic [3:0]  dq;
    logic [1:0]  word_phase;
    logic [7:0]  word_index;

    int checks = 0;
    int fails  = 0;

    always #(CLK_HALF) clk = ~clk;

    qtx_serializer i_qtx_serializer (
        .clk              (clk),
        .rst_n            (rst_n),
        .start_i          (start),
        .clk_div_i        (clk_div),
        .ce_active_high_i (pol),
        .ce_hold_i        (hold),
        .trim_tail_i      (trim),
        .phase_words_i    (words),
        .phase_quad_i     (quad),
        .phase_last_m1_i  (last_m1),
        .phase_pen_m1_i   (pen_m1),
        .word_i           (word_in),
        .sclk_o           (sclk),
        .dq_o             (dq),
        .ce_o             (ce),
        .busy_o           (busy),
        .done_o           (done),
        .word_req_o       (word_req),
        .word_phase_o     (word_phase),
        .word_index_o     (word_index)
    );

    function automatic logic [31:0] gen_word(input int p, input int i);
        return 32'hA5C3_0F96 ^ (32'h9E37_79B9 * 32'(p * 8 + i + 1));
    endfunction

    always_comb word_in = gen_word(int'(word_phase), int'(word_index));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor state
    bit       mon_on = 1'b0;
    logic     prev_sclk;
    logic [3:0] prev_dq;
    int       rises, busy_cnt, done_cnt, ce_bad, hi_bad, dq_bad, hi_len, fetch_n;
    int       mon_top;
    logic     mon_level;
    logic [3:0] got [512];
    int       fph [64];
    int       fidx [64];

    always @(negedge clk) begin
        if (mon_on) begin
            if (busy) busy_cnt++;
            if (done) done_cnt++;
            if (word_req && fetch_n < 64) begin
                fph[fetch_n]  = int'(word_phase);
                fidx[fetch_n] = int'(word_index);
                fetch_n++;
            end
            if (sclk && !prev_sclk) begin
                if (rises < 512) got[rises] = dq;
                rises++;
                if (ce !== mon_level) ce_bad++;
            end
            if (sclk && prev_sclk && dq !== prev_dq) dq_bad++;
            if (sclk) hi_len++;
            if (!sclk && prev_sclk) begin
                if (hi_len != mon_top + 1) hi_bad++;
                hi_len = 0;
            end
        end
        prev_sclk = sclk;
        prev_dq   = dq;
    end

    function automatic int cnt_of(input vec_t v, input int p);
        return (p == 0) ? int'(v.n0) : (p == 1) ? int'(v.n1) : int'(v.n2);
    endfunction
    function automatic int lm1_of(input vec_t v, input int p);
        return (p == 0) ? int'(v.l0) : (p == 1) ? int'(v.l1) : int'(v.l2);
    endfunction
    function automatic int pm1_of(input vec_t v, input int p);
        return (p == 0) ? int'(v.p0) : (p == 1) ? int'(v.p1) : int'(v.p2);
    endfunction

    task automatic drive_cfg(input vec_t v);
        words   = {v.n2, v.n1, v.n0};
        quad    = v.quad;
        last_m1 = {v.l2, v.l1, v.l0};
        pen_m1  = {v.p2, v.p1, v.p0};
        clk_div = v.top;
        pol     = v.pol;
        hold    = v.hold;
        trim    = v.trim;
    endtask

    task automatic run_frame(input vec_t v, input bit poke, input string tag);
        logic [3:0] exp_nib [512];
        int exp_n = 0;
        int efp [64];
        int efi [64];
        int ef_n = 0;
        int exp_busy;
        int bad = 0;
        vec_t other;
        // expected stream and fetch order (R1, R2, R3, R8)
        for (int p = 0; p < 3; p++) begin
            int n = cnt_of(v, p);
            bit q = v.quad[p];
            int full = q ? 8 : 32;
            for (int i = 0; i < n; i++) begin
                logic [31:0] w = gen_word(p, i);
                int rem = n - i;
                int sh = full;
                if (rem == 1) sh = (lm1_of(v, p) + 1 > full) ? full : lm1_of(v, p) + 1;
                else if (rem == 2) sh = (pm1_of(v, p) + 1 > full) ? full : pm1_of(v, p) + 1;
                efp[ef_n] = p; efi[ef_n] = i; ef_n++;
                for (int k = 0; k < sh; k++) begin
                    exp_nib[exp_n] = q ? 4'((w >> (28 - 4 * k)) & 32'hF) : {3'b000, w[31 - k]};
                    exp_n++;
                end
            end
        end
        if (exp_n == 0) begin
            exp_busy = 1;
        end else begin
            exp_busy = 2 + (exp_n + (v.trim ? 0 : 1)) * 2 * (int'(v.top) + 1);
            if (!v.trim) begin
                exp_nib[exp_n] = 4'h0;
                exp_n++;
            end
        end

        drive_cfg(v);
        rises = 0; busy_cnt = 0; done_cnt = 0; ce_bad = 0; hi_bad = 0; dq_bad = 0;
        hi_len = 0; fetch_n = 0; mon_top = int'(v.top); mon_level = v.pol;
        mon_on = 1'b1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (poke) begin
            // R10: start and new configuration while busy must be ignored
            repeat (6) @(negedge clk);
            other = VECS[0];
            drive_cfg(other);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
            drive_cfg(v);
        end
        while (done_cnt == 0) @(negedge clk);
        repeat (4) @(negedge clk);
        mon_on = 1'b0;

        // R8 / R3: number of clock pulses
        check(rises == exp_n, {tag, " R3 R8 pulse count"}, rises, exp_n);
        // R1 / R2: captured lane values
        for (int k = 0; k < exp_n && k < rises; k++) begin
            if (got[k] !== exp_nib[k]) begin
                bad++;
                if (bad <= 4) $display("FAIL %s R2 shift %0d: actual %h expected %h", tag, k, got[k], exp_nib[k]);
            end
        end
        checks++;
        if (bad != 0) fails++;
        // R13 / R1: fetch sequence
        check(fetch_n == ef_n, {tag, " R13 fetch count"}, fetch_n, ef_n);
        for (int f = 0; f < ef_n && f < fetch_n; f++) begin
            check(fph[f] == efp[f] && fidx[f] == efi[f], {tag, " R1 fetch order"},
                  fph[f] * 256 + fidx[f], efp[f] * 256 + efi[f]);
        end
        // R5 / R11: exact busy length
        check(busy_cnt == exp_busy, {tag, " R5 R11 busy cycles"}, busy_cnt, exp_busy);
        // R6
        check(ce_bad == 0, {tag, " R6 ce at rising edges"}, ce_bad, 0);
        // R4
        check(hi_bad == 0, {tag, " R4 high width"}, hi_bad, 0);
        check(dq_bad == 0, {tag, " R4 dq stable while high"}, dq_bad, 0);
        // R10
        check(done_cnt == 1, {tag, " R10 done pulses"}, done_cnt, 1);
        // R7
        check(ce == (v.hold ? v.pol : !v.pol), {tag, " R7 ce after frame"},
              int'(ce), int'(v.hold ? v.pol : !v.pol));
        // R9
        check(!sclk && dq == 4'h0 && !busy, {tag, " R9 idle outputs"}, int'({sclk, dq}), 0);
    endtask

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        drive_cfg('0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check(sclk == 1'b0 && dq == 4'h0 && ce == 1'b1 && !busy && !done && !word_req,
              "R12 reset state", int'({sclk, dq, ce, busy, done, word_req}), int'(9'b0_0000_1000));

        for (int k = 0; k < NVEC; k++) begin
            run_frame(VECS[k], 1'b0, $sformatf("vec%0d", k));
        end
        // directed: start ignored while busy (R10)
        run_frame(VECS[3], 1'b1, "busy-start");
        // directed: held CE closed by an empty frame (R11, R7)
        run_frame(VECS[4], 1'b0, "hold-again");
        run_frame(VECS[5], 1'b0, "empty-close");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_HALF * 2.0 * 150000.0);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule